// File: doc/BRIEF.md
# Eight-Channel Programmable Baud Clock Bank

The block holds eight independent baud clock generators, numbered 0 to 7. Each generator has one 32-bit configuration word on a simple single-cycle register bus. The words are split over two address windows of four consecutive words each. A configuration word sets four things:

- whether the generator runs;
- which of four tick sources drives it;
- whether a fixed divide-by-16 prescale stage comes before the programmable divider;
- the divider count N.

Every generator drives two outputs. The first is a square clock, which toggles once per terminal count and can be routed off chip. The second is a one-cycle strobe at each terminal count, for serial channels on the same clock to use.

The tick sources are clock enables in the `clk` domain. Source 0 is the system baud tick, and sources 1 to 3 are three external tick inputs. Each generator is a two-state controller:

- `ST_OFF`: counters and outputs are held at zero.
- `ST_RUN`: the prescaler and divider count selected ticks.

There are two transitions:

- `OFF->RUN` is taken when the enable bit reads as set.
- `RUN->OFF` is taken when it reads as clear.

Any bus write to a generator's word clears that generator's counters and outputs in the same cycle. Software rounds its divider to an even value so that the output period is the nearest integer division of the source.

Top module: `brg_bank`

## Requirements
- R1: After reset every configuration word reads 0 and every `brg_out` and `brg_pulse` bit is low.
- R2: Generator g (0..7) sits at word address (g/4)*8 + (g%4). Generators 0-3 use addresses 0-3 and generators 4-7 use addresses 8-11. A read returns the full 32-bit value last written there, including bits the generator does not use.
- R3: Writes to the unmapped addresses 4-7 and 12-15 change no configuration word. Reads of those addresses return 0.
- R4: Word layout:
  - bit 0 selects the divide-by-16 prescale;
  - bits [12:1] hold the divider count N;
  - bit 16 is the enable;
  - bits [18:17] select the source;
  - all other bits are storage only.
- R5: While a generator's enable bit is 0, its `brg_out` and `brg_pulse` stay low.
- R6: With the prescale off, an enabled generator pulses `brg_pulse` once every N+1 selected ticks. N=0 gives a pulse on every tick.
- R7: With the prescale on, the pulse interval is 16*(N+1) selected ticks.
- R8: Source value 0 selects `base_tick`. Values 1, 2 and 3 select `ext_tick[0]`, `ext_tick[1]` and `ext_tick[2]`.
- R9: `brg_out` inverts in the cycle of each pulse and changes at no other time except when it is cleared. The result is a 50% duty square wave whose period is twice the pulse interval.
- R10: After the clock edge that writes a generator's word, that generator's `brg_out` and `brg_pulse` are 0. A write to another generator does not disturb the pulse interval of a running generator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_tick | input | 1 | System baud tick enable (source 0) |
| ext_tick | input | 3 | External tick enables (sources 1-3) |
| reg_we | input | 1 | Write strobe for the register bus |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| brg_out | output | 8 | Square clock of each generator |
| brg_pulse | output | 8 | Terminal-count strobe of each generator |

## Verification
The assertions assume the following about the inputs:

- Tick inputs are synchronous one-cycle enables.
- Bus inputs are stable around the clock edge, so a write is a single-cycle strobe whose address and data are valid in that cycle.
- Reset is applied before any write.

The stimulus keeps to these rules in three ways. It drives every input at the falling edge. It makes each external tick a periodic one-cycle strobe with a period of 2, 3 or 4 cycles, while `base_tick` is held high. It sweeps sources, divider counts and prescale across all eight generators and both address windows, so that expected intervals follow as products of those periods.

// File: rtl/brg_pkg.sv
package brg_pkg;
    localparam int NUM_GEN      = 8;
    localparam int GEN_PER_BANK = 4;
    localparam int BANK_STRIDE  = 8;
    localparam int ADDR_W       = 4;
    localparam int HOLE_BIT     = 2;
    localparam int DATA_W       = 32;
    localparam int DIV_W        = 12;
    localparam int PRE_W        = 4;
    localparam int NUM_SRC      = 4;
    localparam int SRC_W        = $clog2(NUM_SRC);

    // Field positions inside a configuration word
    localparam int PRE_BIT  = 0;
    localparam int DIV_LSB  = 1;
    localparam int EN_BIT   = 16;
    localparam int SRC_LSB  = 17;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } gen_state_e;

    function automatic logic [ADDR_W-1:0] gen_addr(input int unsigned g);
        gen_addr = ADDR_W'((g / GEN_PER_BANK) * BANK_STRIDE + (g % GEN_PER_BANK));
    endfunction
endpackage

// File: rtl/brg_regs.sv
module brg_regs
    import brg_pkg::*;
#(
    parameter int N_GEN  = NUM_GEN,
    parameter int AW     = ADDR_W,
    parameter int DW     = DATA_W,
    parameter int DIVW   = DIV_W,
    parameter int SRCW   = SRC_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [AW-1:0]         addr,
    input  logic [DW-1:0]         wdata,
    output logic [DW-1:0]         rdata,
    output logic [N_GEN-1:0]      reload,
    output logic [N_GEN-1:0]      f_en,
    output logic [N_GEN-1:0]      f_pre,
    output logic [N_GEN*SRCW-1:0] f_src,
    output logic [N_GEN*DIVW-1:0] f_div
);
    localparam int IDX_W = $clog2(N_GEN);

    logic [DW-1:0] word_q [N_GEN];

    for (genvar g = 0; g < N_GEN; g++) begin : g_word
        assign reload[g] = we && (addr == gen_addr(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q[g] <= '0;
            end else if (reload[g]) begin
                word_q[g] <= wdata;
            end
        end

        assign f_en[g]                 = word_q[g][EN_BIT];
        assign f_pre[g]                = word_q[g][PRE_BIT];
        assign f_src[g*SRCW +: SRCW]   = word_q[g][SRC_LSB +: SRCW];
        assign f_div[g*DIVW +: DIVW]   = word_q[g][DIV_LSB +: DIVW];
    end

    logic [IDX_W-1:0] rd_idx;
    assign rd_idx = {addr[AW-1], addr[IDX_W-2:0]};

    always_comb begin
        rdata = '0;
        if (!addr[HOLE_BIT]) begin
            rdata = word_q[rd_idx];
        end
    end
endmodule

// File: rtl/brg_core.sv
module brg_core
    import brg_pkg::*;
#(
    parameter int DIVW  = DIV_W,
    parameter int PREW  = PRE_W,
    parameter int NSRC  = NUM_SRC,
    parameter int SRCW  = SRC_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reload,
    input  logic            en,
    input  logic            pre_en,
    input  logic [SRCW-1:0] src_sel,
    input  logic [DIVW-1:0] div_n,
    input  logic [NSRC-1:0] src_ticks,
    output logic            clk_out,
    output logic            pulse
);
    gen_state_e state_q, state_d;

    logic [PREW-1:0] pre_q;
    logic [DIVW-1:0] cnt_q;
    logic            out_q, pulse_q;
    logic            run, tick_sel, stage_tick, term;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  if (en)  state_d = ST_RUN;
            ST_RUN:  if (!en) state_d = ST_OFF;
            default: state_d = ST_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    assign run        = (state_q == ST_RUN) && en;
    assign tick_sel   = src_ticks[src_sel];
    assign stage_tick = pre_en ? (tick_sel && (pre_q == '1)) : tick_sel;
    assign term       = (cnt_q == div_n);

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q   <= '0;
            cnt_q   <= '0;
            out_q   <= 1'b0;
            pulse_q <= 1'b0;
        end else if (reload || !run) begin
            pre_q   <= '0;
            cnt_q   <= '0;
            out_q   <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= stage_tick && term;
            if (pre_en && tick_sel) begin
                pre_q <= pre_q + 1'b1;
            end
            if (stage_tick) begin
                if (term) begin
                    cnt_q <= '0;
                    out_q <= ~out_q;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign clk_out = out_q;
    assign pulse   = pulse_q;
endmodule

// File: rtl/brg_bank.sv
module brg_bank
    import brg_pkg::*;
#(
    parameter int N_GEN = NUM_GEN,
    parameter int AW    = ADDR_W,
    parameter int DW    = DATA_W,
    parameter int DIVW  = DIV_W,
    parameter int NEXT  = NUM_SRC - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_tick,
    input  logic [NEXT-1:0]   ext_tick,
    input  logic              reg_we,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic [N_GEN-1:0]  brg_out,
    output logic [N_GEN-1:0]  brg_pulse
);
    localparam int NSRC = NEXT + 1;
    localparam int SRCW = $clog2(NSRC);

    logic [N_GEN-1:0]      reload, g_en, g_pre;
    logic [N_GEN*SRCW-1:0] g_src;
    logic [N_GEN*DIVW-1:0] g_div;
    logic [NSRC-1:0]       ticks;

    assign ticks = {ext_tick, base_tick};

    brg_regs #(
        .N_GEN(N_GEN), .AW(AW), .DW(DW), .DIVW(DIVW), .SRCW(SRCW)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .reload (reload),
        .f_en   (g_en),
        .f_pre  (g_pre),
        .f_src  (g_src),
        .f_div  (g_div)
    );

    for (genvar g = 0; g < N_GEN; g++) begin : g_gen
        brg_core #(
            .DIVW(DIVW), .PREW(PRE_W), .NSRC(NSRC), .SRCW(SRCW)
        ) u_core (
            .clk       (clk),
            .rst_n     (rst_n),
            .reload    (reload[g]),
            .en        (g_en[g]),
            .pre_en    (g_pre[g]),
            .src_sel   (g_src[g*SRCW +: SRCW]),
            .div_n     (g_div[g*DIVW +: DIVW]),
            .src_ticks (ticks),
            .clk_out   (brg_out[g]),
            .pulse     (brg_pulse[g])
        );
    end
endmodule

// File: rtl/brg_bank_chk.sv
module brg_bank_chk
    import brg_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic                     reg_we,
    input logic [ADDR_W-1:0]        reg_addr,
    input logic [DATA_W-1:0]        reg_wdata,
    input logic [NUM_GEN-1:0]       g_en,
    input logic [NUM_GEN-1:0]       g_pre,
    input logic [NUM_GEN*SRC_W-1:0] g_src,
    input logic [NUM_GEN*DIV_W-1:0] g_div,
    input logic [NUM_GEN-1:0]       brg_out,
    input logic [NUM_GEN-1:0]       brg_pulse
);
    // R3
    unmapped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr[HOLE_BIT]) |=> $stable({g_en, g_pre, g_src, g_div}));

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_chk
        // R2
        write_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && reg_addr == gen_addr(g)) |=>
                (g_en[g] == $past(reg_wdata[EN_BIT]) &&
                 g_pre[g] == $past(reg_wdata[PRE_BIT]) &&
                 g_src[g*SRC_W +: SRC_W] == $past(reg_wdata[SRC_LSB +: SRC_W]) &&
                 g_div[g*DIV_W +: DIV_W] == $past(reg_wdata[DIV_LSB +: DIV_W])));

        // R5
        off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !g_en[g] |-> (!brg_out[g] && !brg_pulse[g]));

        // R9
        toggle_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            brg_pulse[g] |-> (brg_out[g] != $past(brg_out[g])));

        // R9
        no_stray_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (brg_out[g] != $past(brg_out[g])) |-> (brg_pulse[g] || !brg_out[g]));

        // R10
        reload_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && reg_addr == gen_addr(g)) |=> (!brg_out[g] && !brg_pulse[g]));
    end
endmodule

bind brg_bank brg_bank_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .g_en      (g_en),
    .g_pre     (g_pre),
    .g_src     (g_src),
    .g_div     (g_div),
    .brg_out   (brg_out),
    .brg_pulse (brg_pulse)
);

// File: tb/brg_bank_test.sv
module brg_bank_test;
    import brg_pkg::*;

    localparam int TMO = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_tick = 1'b1;
    logic [2:0]  ext_tick = 3'b000;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  brg_out, brg_pulse;

    int checks = 0;
    int errors = 0;
    int ph [3] = '{0, 0, 0};

    always #2 clk = ~clk;

    brg_bank uut (
        .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .ext_tick(ext_tick),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .brg_out(brg_out), .brg_pulse(brg_pulse)
    );

    // External tick k is a one-cycle strobe every k+2 cycles
    always @(negedge clk) begin
        for (int k = 0; k < 3; k++) begin
            ph[k] = (ph[k] == k + 1) ? 0 : ph[k] + 1;
            ext_tick[k] = (ph[k] == 0);
        end
    end

    function automatic logic [31:0] cfg(input bit en, input int src, input int n, input bit pre);
        logic [31:0] w;
        w = '0;
        w[0]     = pre;
        w[12:1]  = 12'(n);
        w[16]    = en;
        w[18:17] = 2'(src);
        return w;
    endfunction

    function automatic logic [3:0] addr_of(input int g);
        return 4'((g / 4) * 8 + (g % 4));
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_pulse(input int g, output int c);
        c = 0;
        do begin
            @(negedge clk);
            c++;
        end while (!brg_pulse[g] && c < TMO);
        if (c >= TMO) check(1'b0, "timeout", c, TMO);
    endtask

    task automatic measure(input int g, input int exp, input string req);
        int c0, c1, c2;
        logic o1, o2;
        wait_pulse(g, c0);
        wait_pulse(g, c1);
        o1 = brg_out[g];
        wait_pulse(g, c2);
        o2 = brg_out[g];
        check(c1 == exp, req, c1, exp);
        check(c2 == exp, req, c2, exp);
        check(o1 != o2, "R9 toggle per pulse", o2, !o1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int per [4] = '{1, 2, 3, 4};
        int nv [4] = '{0, 1, 2, 5};
        int gsel, c;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int g = 0; g < 8; g++) begin
            rd(addr_of(g), d);
            check(d == 0, "R1 reset word", d, 0);
        end
        check(brg_out == 0 && brg_pulse == 0, "R1 outputs low", {brg_out, brg_pulse}, 0);

        // R2 address map and readback (enable clear, spare bits set)
        for (int g = 0; g < 8; g++) wr(addr_of(g), 32'hA5A0_0000 ^ (32'(g) << 20) ^ 32'h0000_8F2E ^ 32'(g));
        for (int g = 0; g < 8; g++) begin
            rd(addr_of(g), d);
            check(d == (32'hA5A0_0000 ^ (32'(g) << 20) ^ 32'h0000_8F2E ^ 32'(g)) && !d[16],
                  "R2 readback", d, 32'hA5A0_0000 ^ (32'(g) << 20) ^ 32'h0000_8F2E ^ 32'(g));
        end

        // R3 unmapped addresses
        for (int a = 4; a < 8; a++) begin
            wr(4'(a), 32'hFFFF_FFFF);
            wr(4'(a + 8), 32'hFFFF_FFFF);
        end
        for (int a = 4; a < 8; a++) begin
            rd(4'(a), d);     check(d == 0, "R3 hole read", d, 0);
            rd(4'(a + 8), d); check(d == 0, "R3 hole read", d, 0);
        end
        for (int g = 0; g < 8; g++) begin
            rd(addr_of(g), d);
            check(d == (32'hA5A0_0000 ^ (32'(g) << 20) ^ 32'h0000_8F2E ^ 32'(g)),
                  "R3 mapped unchanged", d, 32'hA5A0_0000 ^ (32'(g) << 20) ^ 32'h0000_8F2E ^ 32'(g));
        end

        // R5 disabled generator stays quiet
        for (int g = 0; g < 8; g++) wr(addr_of(g), 32'h0);
        wr(addr_of(0), cfg(1'b0, 0, 0, 1'b0));
        c = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (brg_out[0] || brg_pulse[0]) c++;
        end
        check(c == 0, "R5 disabled quiet", c, 0);

        // R4 R6 R8 sweep of sources and divider counts, prescale off
        gsel = 0;
        for (int s = 0; s < 4; s++) begin
            for (int j = 0; j < 4; j++) begin
                wr(addr_of(gsel), cfg(1'b1, s, nv[j], 1'b0));
                measure(gsel, (nv[j] + 1) * per[s], "R6 R8 interval");
                wr(addr_of(gsel), 32'h0);
                gsel = (gsel + 1) % 8;
            end
        end

        // R7 prescale
        for (int s = 0; s < 2; s++) begin
            for (int n = 0; n < 3; n += 2) begin
                wr(addr_of(gsel), cfg(1'b1, s, n, 1'b1));
                measure(gsel, 16 * (n + 1) * per[s], "R7 prescale interval");
                wr(addr_of(gsel), 32'h0);
                gsel = (gsel + 1) % 8;
            end
        end

        // R10 write clears the written generator
        wr(addr_of(3), cfg(1'b1, 0, 3, 1'b0));
        wait_pulse(3, c);
        wr(addr_of(3), cfg(1'b1, 0, 3, 1'b0));
        check(!brg_out[3] && !brg_pulse[3], "R10 reload clears", {brg_out[3], brg_pulse[3]}, 0);

        // R10 other generators undisturbed by writes
        wr(addr_of(5), cfg(1'b1, 0, 6, 1'b0));
        fork
            measure(5, 7, "R10 isolation interval");
            begin
                for (int i = 0; i < 6; i++) wr(addr_of(3), cfg(1'b1, 0, i, 1'b0));
            end
        join

        // R5 disable while running
        wr(addr_of(5), cfg(1'b0, 0, 6, 1'b0));
        c = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (brg_out[5] || brg_pulse[5]) c++;
        end
        check(c == 0, "R5 disabled after run", c, 0);

        // R6 all eight generators running together
        for (int g = 0; g < 8; g++) wr(addr_of(g), cfg(1'b1, 0, g + 1, 1'b0));
        for (int g = 0; g < 8; g++) measure(g, g + 2, "R6 parallel interval");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule